// File: doc/BRIEF.md
# Burst Fault Sequencer

This block times a short, full-rate capture burst around an injected disturbance. When it accepts a start pulse, it raises its capture write strobe on every clock. The burst runs through three back-to-back windows. The first is a quiet window that records steady-state behaviour. The second is a window with the fault drive asserted. The third is a window with the fault drive released. After the third window the strobe drops and a one-cycle completion pulse is given. The three window lengths are cycle counts. They are sampled once, when the start is accepted, so the host may change them freely during a burst.

The write side follows valid/ready rules. `cap_valid_o` depends only on the sequencer state and never waits for ready. A sample cannot be held back, because the captured signal does not pause. A cycle with valid high and ready low therefore means a sample was lost. The sequencer aborts at once: it goes to the completion state, releases the fault drive and sets a sticky overflow flag. The capture memory, its reader and the disturbed system lie outside this block.

Top module: `burst_fault_seq`

## Requirements
- R1: After reset, `cap_valid_o`, `fault_o`, `busy_o`, `done_o` and `overflow_o` are low and `cap_phase_o` is 3.
- R2: A start pulse seen in the idle state latches the three lengths. If any length is nonzero, `cap_valid_o` and `busy_o` are high from the next cycle.
- R3: The quiet window lasts `pre_len_i` cycles. In it `cap_valid_o`=1, `fault_o`=0 and `cap_phase_o`=0.
- R4: The fault window follows directly and lasts `on_len_i` cycles. In it `cap_valid_o`=1, `fault_o`=1 and `cap_phase_o`=1.
- R5: The release window follows directly and lasts `off_len_i` cycles. In it `cap_valid_o`=1, `fault_o`=0 and `cap_phase_o`=2.
- R6: After the last window, `done_o` is high for exactly one cycle with `cap_valid_o` low, and then the block is idle. Without overflow, the number of accepted samples equals the sum of the three lengths.
- R7: A window of length zero is skipped. If all three lengths are zero, `done_o` is high in the cycle after the start.
- R8: Changes to the length inputs during a burst have no effect on its windows.
- R9: A start pulse while a burst is running, or in the completion cycle, is ignored.
- R10: `cap_valid_o` high with `cap_ready_i` low ends the burst. The next cycle has `done_o`=1, `overflow_o`=1, and `cap_valid_o` and `fault_o` low.
- R11: `overflow_o` stays set after an aborted burst until the next accepted start clears it.
- R12: `fault_o` is never high while `cap_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only in the idle state |
| pre_len_i | input | CNT_W | Quiet window length in cycles |
| on_len_i | input | CNT_W | Fault window length in cycles |
| off_len_i | input | CNT_W | Release window length in cycles |
| cap_ready_i | input | 1 | Capture memory can accept a sample (low = full) |
| cap_valid_o | output | 1 | Sample write strobe, one per clock during the burst |
| cap_phase_o | output | 2 | Window tag: 0 quiet, 1 fault, 2 release, 3 none |
| fault_o | output | 1 | Fault drive to the disturbed system |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | Sticky flag: last burst lost a sample |

## Verification
A stuck or skipped state shows up at the ports in the cycle it happens. Examples are a window that runs one cycle long or short, or a zero-length window that is not skipped. Each of these moves the edge of `cap_phase_o` or `fault_o` away from the cycle the bench predicts from the latched lengths. A counter that loads the wrong value shows up in the same way. A lost abort leaves `cap_valid_o` high in the cycle after a stall, where `done_o` and `overflow_o` are due. A start honoured while busy, or lengths read late, restart or stretch a window within a few cycles.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int NWIN = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_FON  = 3'd2,
    ST_FOFF = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

  localparam logic [1:0] PH_PRE  = 2'd0;
  localparam logic [1:0] PH_FON  = 2'd1;
  localparam logic [1:0] PH_FOFF = 2'd2;
  localparam logic [1:0] PH_NONE = 2'd3;

  function automatic seq_state_t win_state(input logic [1:0] idx);
    case (idx)
      2'd0:    return ST_PRE;
      2'd1:    return ST_FON;
      default: return ST_FOFF;
    endcase
  endfunction
endpackage

// File: rtl/bfs_len_latch.sv
module bfs_len_latch
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [NWIN-1:0][CNT_W-1:0] len_i,
  output logic [NWIN-1:0][CNT_W-1:0] len_q,
  output logic [NWIN-1:0]            nz_q
);
  for (genvar g = 0; g < NWIN; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q[g] <= '0;
      else if (load_i) len_q[g] <= len_i[g];
    end
    assign nz_q[g] = |len_q[g];
  end

  // R8: latched lengths move only on an accepted start
  p_hold_lengths_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(len_q));
endmodule

// File: rtl/bfs_window_ctr.sv
module bfs_window_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (load_i) remain_q <= load_val_i;
    else if (dec_i)  remain_q <= remain_q - 1'b1;
  end

  assign last_o = (remain_q == CNT_W'(1));

  // R6: a window never counts past its end
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (remain_q > CNT_W'(1)));
  // R7: empty windows are never entered
  p_no_empty_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (load_val_i != '0));
endmodule

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       ready_i,
  input  logic [NWIN-1:0][CNT_W-1:0] raw_len_i,
  input  logic [NWIN-1:0][CNT_W-1:0] lat_len_i,
  input  logic [NWIN-1:0]            lat_nz_i,
  input  logic                       ctr_last_i,
  output logic                       latch_o,
  output logic                       ctr_load_o,
  output logic [CNT_W-1:0]           ctr_val_o,
  output logic                       ctr_dec_o,
  output seq_state_t                 state_o,
  output logic                       ovf_o
);
  seq_state_t state_q, state_d;
  logic       ovf_q, ovf_set, ovf_clr;
  logic [NWIN-1:0] raw_nz;
  logic       is_write;
  logic [2:0] pick;

  for (genvar g = 0; g < NWIN; g++) begin : g_nz
    assign raw_nz[g] = |raw_len_i[g];
  end

  // returns {found, index} of the first nonempty window after 'after'
  function automatic logic [2:0] next_win(input logic [NWIN-1:0] nz, input int after);
    logic [2:0] r;
    r = 3'b000;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (i > after && nz[i]) r = {1'b1, 2'(i)};
    end
    return r;
  endfunction

  assign is_write = (state_q == ST_PRE) || (state_q == ST_FON) || (state_q == ST_FOFF);

  always_comb begin
    state_d    = state_q;
    latch_o    = 1'b0;
    ctr_load_o = 1'b0;
    ctr_val_o  = '0;
    ctr_dec_o  = 1'b0;
    ovf_set    = 1'b0;
    ovf_clr    = 1'b0;
    pick       = 3'b000;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          latch_o = 1'b1;
          ovf_clr = 1'b1;
          pick    = next_win(raw_nz, -1);
          if (pick[2]) begin
            state_d    = win_state(pick[1:0]);
            ctr_load_o = 1'b1;
            ctr_val_o  = raw_len_i[pick[1:0]];
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_PRE, ST_FON, ST_FOFF: begin
        if (!ready_i) begin
          ovf_set = 1'b1;
          state_d = ST_DONE;
        end else if (ctr_last_i) begin
          pick = next_win(lat_nz_i, int'(state_q) - 1);
          if (pick[2]) begin
            state_d    = win_state(pick[1:0]);
            ctr_load_o = 1'b1;
            ctr_val_o  = lat_len_i[pick[1:0]];
          end else begin
            state_d = ST_DONE;
          end
        end else begin
          ctr_dec_o = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ovf_clr)      ovf_q <= 1'b0;
      else if (ovf_set) ovf_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign ovf_o   = ovf_q;

  // R10: a refused sample aborts the burst with overflow flagged
  p_abort_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_write && !ready_i) |=> (state_q == ST_DONE && ovf_q));
  // R6: completion lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
  // R11: an accepted start clears overflow
  p_clear_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> !ovf_q);
  // R9: mid-window, start has no effect on the state
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_write && ready_i && !ctr_last_i) |=> $stable(state_q));
  // R2: start with work to do enters a write window
  p_start_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && (|raw_nz)) |=>
      (state_q == ST_PRE || state_q == ST_FON || state_q == ST_FOFF));
endmodule

// File: rtl/bfs_out_dec.sv
module bfs_out_dec
  import burst_seq_pkg::*;
(
  input  seq_state_t state_i,
  output logic       valid_o,
  output logic [1:0] phase_o,
  output logic       fault_o,
  output logic       busy_o,
  output logic       done_o
);
  always_comb begin
    valid_o = 1'b0;
    phase_o = PH_NONE;
    fault_o = 1'b0;
    done_o  = 1'b0;
    case (state_i)
      ST_PRE:  begin valid_o = 1'b1; phase_o = PH_PRE; end
      ST_FON:  begin valid_o = 1'b1; phase_o = PH_FON; fault_o = 1'b1; end
      ST_FOFF: begin valid_o = 1'b1; phase_o = PH_FOFF; end
      ST_DONE: done_o = 1'b1;
      default: ;
    endcase
    busy_o = valid_o;
  end
endmodule

// File: rtl/burst_fault_seq.sv
module burst_fault_seq
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pre_len_i,
  input  logic [CNT_W-1:0] on_len_i,
  input  logic [CNT_W-1:0] off_len_i,
  input  logic             cap_ready_i,
  output logic             cap_valid_o,
  output logic [1:0]       cap_phase_o,
  output logic             fault_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overflow_o
);
  logic [NWIN-1:0][CNT_W-1:0] len_in, len_q;
  logic [NWIN-1:0]            nz_q;
  logic                       latch, ctr_load, ctr_dec, ctr_last;
  logic [CNT_W-1:0]           ctr_val;
  seq_state_t                 state;

  assign len_in = {off_len_i, on_len_i, pre_len_i};

  bfs_len_latch #(.CNT_W(CNT_W)) u_lens (
    .clk(clk), .rst_n(rst_n), .load_i(latch),
    .len_i(len_in), .len_q(len_q), .nz_q(nz_q)
  );

  bfs_window_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load_i(ctr_load),
    .load_val_i(ctr_val), .dec_i(ctr_dec), .last_o(ctr_last)
  );

  bfs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(cap_ready_i),
    .raw_len_i(len_in), .lat_len_i(len_q), .lat_nz_i(nz_q),
    .ctr_last_i(ctr_last), .latch_o(latch), .ctr_load_o(ctr_load),
    .ctr_val_o(ctr_val), .ctr_dec_o(ctr_dec), .state_o(state), .ovf_o(overflow_o)
  );

  bfs_out_dec u_dec (
    .state_i(state), .valid_o(cap_valid_o), .phase_o(cap_phase_o),
    .fault_o(fault_o), .busy_o(busy_o), .done_o(done_o)
  );

  // R12: the fault drive only acts inside a write burst
  p_fault_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> cap_valid_o);
  // R6: running and completing are exclusive
  p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o}));
  // R10: after a refused sample, the fault drive is released
  p_fault_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid_o && !cap_ready_i) |=> (!fault_o && !cap_valid_o && done_o));
endmodule

// File: tb/burst_fault_seq_test.sv
module burst_fault_seq_test;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] pre_len = '0, on_len = '0, off_len = '0;
  logic          ready = 1'b1;
  logic          valid, fault, busy, done, ovf;
  logic [1:0]    phase;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_fault_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .pre_len_i(pre_len), .on_len_i(on_len), .off_len_i(off_len),
    .cap_ready_i(ready), .cap_valid_o(valid), .cap_phase_o(phase),
    .fault_o(fault), .busy_o(busy), .done_o(done), .overflow_o(ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_phase(input int k, input int p, input int o, input int f);
    if (k < p) return 0;
    if (k < p + o) return 1;
    if (k < p + o + f) return 2;
    return 3;
  endfunction

  function automatic string phase_req(input int ph);
    if (ph == 0) return "R3";
    if (ph == 1) return "R4";
    return "R5";
  endfunction

  // one burst; stall_at < 0 means no refused sample
  task automatic run_burst(input int p, input int o, input int f, input int stall_at,
                           input bit noise, input bit poke_done);
    int  total, beats, last_k, ph;
    bit  stalled;
    total   = p + o + f;
    stalled = (stall_at >= 0) && (stall_at < total);
    last_k  = stalled ? stall_at + 1 : total;
    beats   = 0;
    @(negedge clk);
    pre_len = CW'(p); on_len = CW'(o); off_len = CW'(f);
    start = 1'b1; ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < last_k; k++) begin
      ph = exp_phase(k, p, o, f);
      chk(phase_req(ph), "valid", int'(valid), 1);
      chk(phase_req(ph), "phase", int'(phase), ph);
      chk(phase_req(ph), "fault", int'(fault), (ph == 1) ? 1 : 0);
      if (k == 0) begin
        chk("R2", "busy after start", int'(busy), 1);
        chk("R11", "overflow cleared by start", int'(ovf), 0);
      end
      if (noise) begin
        pre_len = CW'($urandom_range(0, 400));   // R8: must not matter
        on_len  = CW'($urandom_range(0, 400));
        off_len = CW'($urandom_range(0, 400));
        start   = ($urandom_range(0, 3) == 0);   // R9: must be ignored
      end
      ready = (k == stall_at) ? 1'b0 : 1'b1;
      if (ready && valid) beats++;
      @(negedge clk);
    end
    start = poke_done;
    ready = 1'b1;
    chk(stalled ? "R10" : (total == 0 ? "R7" : "R6"), "done", int'(done), 1);
    chk(stalled ? "R10" : "R6", "valid at done", int'(valid), 0);
    chk("R10", "fault at done", int'(fault), 0);
    chk(stalled ? "R10" : "R6", "overflow at done", int'(ovf), stalled ? 1 : 0);
    chk(stalled ? "R10" : "R6", "accepted samples", beats, stalled ? stall_at : total);
    @(negedge clk);
    start = 1'b0;
    chk(poke_done ? "R9" : "R6", "idle valid", int'(valid), 0);
    chk("R6", "done one cycle", int'(done), 0);
    chk("R6", "idle busy", int'(busy), 0);
    chk("R11", "overflow held", int'(ovf), stalled ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1", "valid", int'(valid), 0);
    chk("R1", "fault", int'(fault), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "overflow", int'(ovf), 0);
    chk("R1", "phase", int'(phase), 3);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_burst(3, 200, 200, -1, 1'b0, 1'b0);
    run_burst(0, 5, 0, -1, 1'b0, 1'b0);     // R7 skip quiet and release
    run_burst(0, 0, 0, -1, 1'b0, 1'b0);     // R7 all empty
    run_burst(4, 0, 6, -1, 1'b1, 1'b1);     // R7 skip fault, R8, R9
    run_burst(2, 3, 4, 0, 1'b0, 1'b0);      // R10 first sample refused
    run_burst(2, 3, 4, 3, 1'b0, 1'b0);      // R10 inside fault window
    run_burst(1, 1, 1, -1, 1'b0, 1'b0);     // R11 cleared by new start
    run_burst(2, 3, 4, 8, 1'b0, 1'b1);      // R10 last sample refused
    run_burst(1, 1, 1, -1, 1'b0, 1'b0);
    // random bursts
    for (int n = 0; n < 24; n++) begin
      int p, o, f, s;
      p = $urandom_range(0, 300);
      o = $urandom_range(0, 300);
      f = $urandom_range(0, 300);
      s = ($urandom_range(0, 3) == 0) ? $urandom_range(0, p + o + f) : -1;
      run_burst(p, o, f, s, 1'b1, $urandom_range(0, 1) == 1);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule